// File: doc/BRIEF.md
# Battery Backup Switchover and Battery Test Controller

This controller decides when a supervised supply output is handed over from the main supply to a backup battery, and it schedules battery health tests. All of its inputs are digital flags from comparators outside the block. The flags say whether the main supply is under the reset threshold, under the battery voltage, or back above the battery by a margin. Another flag says whether main power is present at all, and the last says whether the battery sits under its OK level. The block drives a battery-on indicator, a switch-select line for the analog power path, a test-load enable for the battery load resistor, and a battery-OK indicator.

A one-time seal keeps a new battery isolated until main power has appeared once. After that, a loss of main power moves the output onto the battery only when the main supply is both under the reset threshold and under the battery voltage. It returns to main power only when a separate return flag says the main supply is clearly above the battery. When main power is up and the block is not in backup, the battery is loaded for a fixed test window. At the end of the window its condition is sampled onto the OK output. The test then repeats on a long period. Both the window and the period are parameters counted in ticks of a slow timebase strobe.

Top module: `batt_backup_ctrl`

## Requirements
- R1: Backup mode is entered on the clock edge where both main_below_rst and main_below_batt are 1, the block is not sealed, and it is not already in backup. If either flag is 0, backup is not entered.
- R2: Once in backup, the block stays there whatever the threshold flags do, until main_return is 1. It then leaves backup on that clock edge.
- R3: batt_on and sel_batt are both 1 exactly while the block is in backup mode, and both are 0 otherwise.
- R4: After reset the block is sealed, and while sealed backup mode cannot be entered. The first cycle with main_present = 1 unseals it. If the block is sealed while in backup, it leaves backup on the next edge.
- R5: seal_rearm = 1 seals the block again only while main_present = 0. When main_present = 1, seal_rearm has no effect.
- R6: When main power is present, the block is not in backup, and no test schedule is running, a test starts on the next edge. test_load_en is 1 for TEST_TICKS ticks of tick, and a cycle without tick does not advance the window.
- R7: After a test ends, the next test starts once PERIOD_TICKS further ticks have passed.
- R8: On the edge that ends a test, batt_ok takes the value of !batt_low. batt_ok then holds until the next test completes, whatever batt_low does in between.
- R9: While in backup, batt_ok and test_load_en are 0 from the first backup cycle. The held result is cleared, so batt_ok stays 0 after backup until a new test completes. A new test starts on the edge after backup ends if main power is present.
- R10: While rst is 1 and in the first cycle after it, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe that advances the test counters |
| main_below_rst | input | 1 | Main supply is under the reset threshold |
| main_below_batt | input | 1 | Main supply is under the battery voltage |
| main_return | input | 1 | Main supply is back above the battery by the return margin |
| main_present | input | 1 | Main supply is present |
| batt_low | input | 1 | Battery is under its OK level |
| seal_rearm | input | 1 | Request to seal the battery again (only acted on with main absent) |
| batt_on | output | 1 | High while in backup mode |
| batt_ok | output | 1 | Latched result of the last battery test |
| test_load_en | output | 1 | Enables the battery test load |
| sel_batt | output | 1 | Selects the battery as the source of the output |

## Verification
Entry into backup and the battery test result can fall in the same cycle. This happens when backup begins while a latched OK result is high: the OK output must drop in that very cycle, and the aborted test must not later write a stale pass. The bench provokes this by reaching a passing result and then raising both entry flags on the next cycle. It judges that batt_on rises while batt_ok falls on that edge, and that batt_ok stays low through the return to main power until the restarted window completes. A second collision is a seal re-arm while in backup, which must be followed one edge later by the drop out of backup.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

    typedef enum logic [1:0] {
        TST_IDLE = 2'd0,
        TST_LOAD = 2'd1,
        TST_GAP  = 2'd2
    } tst_state_t;

    typedef struct packed {
        logic below_rst;
        logic below_batt;
        logic back_above;
    } sw_flags_t;

    function automatic int cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/bbc_seal.sv
module bbc_seal (
    input  logic clk,
    input  logic rst,
    input  logic main_present,
    input  logic seal_rearm,
    output logic sealed
);
    always_ff @(posedge clk) begin
        if (rst)
            sealed <= 1'b1;
        else if (main_present)
            sealed <= 1'b0;
        else if (seal_rearm)
            sealed <= 1'b1;
    end

    // R5: a re-arm request is ignored while main power is present
    assert_rearm_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        main_present |=> !sealed);

    // R4: the seal can only be set by reset or a re-arm request
    assert_seal_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(sealed) |-> $past(seal_rearm));
endmodule

// File: rtl/bbc_switch.sv
module bbc_switch
    import bbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sw_flags_t flags,
    input  logic      sealed,
    output logic      in_backup
);
    logic enter_ok;

    assign enter_ok = flags.below_rst && flags.below_batt && !sealed;

    always_ff @(posedge clk) begin
        if (rst)
            in_backup <= 1'b0;
        else if (sealed)
            in_backup <= 1'b0;
        else if (!in_backup)
            in_backup <= enter_ok;
        else if (flags.back_above)
            in_backup <= 1'b0;
    end

    // R1: entry needs both supply conditions together
    assert_enter_needs_both_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(in_backup) |-> $past(flags.below_rst && flags.below_batt));

    // R4: a sealed controller is out of backup on the next edge
    assert_seal_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        sealed |=> !in_backup);

    // R2: backup is left only through the return flag or the seal
    assert_exit_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(in_backup) |-> $past(flags.back_above || sealed));
endmodule

// File: rtl/bbc_tester.sv
module bbc_tester
    import bbc_pkg::*;
#(
    parameter int TEST_TICKS   = 3,
    parameter int PERIOD_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic main_present,
    input  logic in_backup,
    input  logic batt_low,
    output logic load_en,
    output logic ok
);
    localparam int CW = cnt_width(TEST_TICKS, PERIOD_TICKS);
    localparam logic [CW-1:0] LOAD_LAST = CW'(TEST_TICKS - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(PERIOD_TICKS - 1);

    tst_state_t    st;
    logic [CW-1:0] cnt;
    logic          ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= TST_IDLE;
            cnt  <= '0;
            ok_q <= 1'b0;
        end else if (in_backup || !main_present) begin
            st  <= TST_IDLE;
            cnt <= '0;
            if (in_backup)
                ok_q <= 1'b0;
        end else begin
            case (st)
                TST_IDLE: begin
                    st  <= TST_LOAD;
                    cnt <= '0;
                end
                TST_LOAD: if (tick) begin
                    if (cnt == LOAD_LAST) begin
                        st   <= TST_GAP;
                        cnt  <= '0;
                        ok_q <= !batt_low;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TST_GAP: if (tick) begin
                    if (cnt == GAP_LAST) begin
                        st  <= TST_LOAD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= TST_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign load_en = (st == TST_LOAD) && !in_backup;
    assign ok      = ok_q && !in_backup;

    // R6: the test load is only applied after a cycle with main power
    assert_load_powered_R6: assert property (@(posedge clk) disable iff (rst)
        load_en |-> $past(main_present));

    // R9: backup clears the held result by the next edge
    assert_backup_clears_R9: assert property (@(posedge clk) disable iff (rst)
        in_backup |=> !ok_q);

    // R8: the result only moves at the end of a test window or in backup
    assert_ok_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!in_backup && st != TST_LOAD) |=> $stable(ok_q));
endmodule

// File: rtl/batt_backup_ctrl.sv
module batt_backup_ctrl
    import bbc_pkg::*;
#(
    parameter int TEST_TICKS   = 3,
    parameter int PERIOD_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic main_below_rst,
    input  logic main_below_batt,
    input  logic main_return,
    input  logic main_present,
    input  logic batt_low,
    input  logic seal_rearm,
    output logic batt_on,
    output logic batt_ok,
    output logic test_load_en,
    output logic sel_batt
);
    sw_flags_t flags;
    logic      sealed;
    logic      in_backup;

    assign flags = '{below_rst: main_below_rst,
                     below_batt: main_below_batt,
                     back_above: main_return};

    bbc_seal u_seal (
        .clk          (clk),
        .rst          (rst),
        .main_present (main_present),
        .seal_rearm   (seal_rearm),
        .sealed       (sealed)
    );

    bbc_switch u_switch (
        .clk       (clk),
        .rst       (rst),
        .flags     (flags),
        .sealed    (sealed),
        .in_backup (in_backup)
    );

    bbc_tester #(
        .TEST_TICKS   (TEST_TICKS),
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_tester (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .main_present (main_present),
        .in_backup    (in_backup),
        .batt_low     (batt_low),
        .load_en      (test_load_en),
        .ok           (batt_ok)
    );

    assign batt_on  = in_backup;
    assign sel_batt = in_backup;

    // R3: the indicator and the switch select never disagree
    assert_on_matches_select_R3: assert property (@(posedge clk) disable iff (rst)
        batt_on == sel_batt);

    // R9: no test load and no OK indication while on battery
    assert_quiet_in_backup_R9: assert property (@(posedge clk) disable iff (rst)
        batt_on |-> (!test_load_en && !batt_ok));
endmodule

// File: tb/batt_backup_ctrl_tb.sv
`timescale 1ns/1ps
module batt_backup_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic mbr = 1'b0, mbb = 1'b0, mret = 1'b0, mpres = 1'b0;
    logic blow = 1'b0, rearm = 1'b0;
    logic batt_on, batt_ok, test_load_en, sel_batt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    batt_backup_ctrl #(.TEST_TICKS(3), .PERIOD_TICKS(5)) u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .main_below_rst(mbr), .main_below_batt(mbb), .main_return(mret),
        .main_present(mpres), .batt_low(blow), .seal_rearm(rearm),
        .batt_on(batt_on), .batt_ok(batt_ok),
        .test_load_en(test_load_en), .sel_batt(sel_batt)
    );

    // fields: below_rst, below_batt, return, present, rearm, expected batt_on
    localparam int NV = 15;
    localparam logic [5:0] VEC [NV] = '{
        6'b110_000,  // R4 sealed: no entry
        6'b000_100,  // R4 main present unseals
        6'b100_000,  // R1 only one condition
        6'b010_000,  // R1 only the other condition
        6'b110_001,  // R1 both: enter
        6'b000_001,  // R2 held without return flag
        6'b001_000,  // R2 return flag exits
        6'b110_001,  // R1 enter again
        6'b110_011,  // R4 re-arm while in backup: still on this edge
        6'b110_000,  // R4 sealed forces exit
        6'b110_000,  // R4 sealed blocks entry
        6'b000_100,  // R4 unseal again
        6'b110_001,  // R1 enter
        6'b001_110,  // R5 re-arm with main present, return exits
        6'b110_001   // R5 re-arm was ignored: entry allowed
    };

    task automatic check(input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) step();
        check(batt_on, 1'b0, "R10 reset batt_on");
        check(sel_batt, 1'b0, "R10 reset sel_batt");
        check(batt_ok, 1'b0, "R10 reset batt_ok");
        check(test_load_en, 1'b0, "R10 reset test_load_en");
        rst = 1'b0;
        step();
        check(batt_on, 1'b0, "R10 first cycle batt_on");
        check(test_load_en, 1'b0, "R10 first cycle test_load_en");

        for (int i = 0; i < NV; i++) begin
            {mbr, mbb, mret, mpres, rearm} = VEC[i][5:1];
            step();
            check(batt_on, VEC[i][0], $sformatf("R1/R2/R4/R5 vector %0d batt_on", i));
            check(sel_batt, VEC[i][0], $sformatf("R3 vector %0d sel_batt", i));
        end

        // directed: battery test schedule
        rst = 1'b1; {mbr, mbb, mret, mpres, rearm} = '0;
        step(); step();
        rst = 1'b0; mpres = 1'b1; tick = 1'b1; blow = 1'b0;
        step();                                             // E1: test starts
        check(test_load_en, 1'b1, "R6 load on after power");
        check(batt_ok, 1'b0, "R8 no result before first test");
        tick = 1'b0; step();                                // no tick: window frozen
        tick = 1'b1;
        step(); step();                                     // two of three ticks
        check(test_load_en, 1'b1, "R6 window frozen without tick");
        step();                                             // third tick ends test
        check(test_load_en, 1'b0, "R6 load off after TEST_TICKS");
        check(batt_ok, 1'b1, "R8 good battery result");
        repeat (4) step();
        check(test_load_en, 1'b0, "R7 still in gap");
        step();
        check(test_load_en, 1'b1, "R7 next test after PERIOD_TICKS");
        blow = 1'b1;
        step(); step();
        check(batt_ok, 1'b1, "R8 held during test");
        step();
        check(batt_ok, 1'b0, "R8 weak battery result");
        blow = 1'b0;
        repeat (5) step();
        check(test_load_en, 1'b1, "R7 third test");
        repeat (3) step();
        check(batt_ok, 1'b1, "R8 good again");

        // collision: backup entry while OK is high
        mpres = 1'b0; mbr = 1'b1; mbb = 1'b1;
        step();
        check(batt_on, 1'b1, "R9 backup entered");
        check(batt_ok, 1'b0, "R9 OK forced low in backup");
        check(test_load_en, 1'b0, "R9 no load in backup");
        mbr = 1'b0; mbb = 1'b0; mret = 1'b1; mpres = 1'b1;
        step();
        check(batt_on, 1'b0, "R2 returned to main");
        check(batt_ok, 1'b0, "R9 OK stays cleared after backup");
        mret = 1'b0;
        step();
        check(test_load_en, 1'b1, "R9 test restarts after backup");
        step(); step();
        check(batt_ok, 1'b0, "R9 still cleared during retest");
        step();
        check(batt_ok, 1'b1, "R9 OK after retest");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule